// File: doc/BRIEF.md
# Width-Selectable Serial Data FIFO

This block is a 256-byte first-in first-out buffer that sits between a processor-facing data path and a serial shifting engine. Each entry is one byte, one 16-bit halfword or one 32-bit word, chosen at run time by a width code. Entries enter through a valid/ready push port and leave through a valid/ready pop port. Data is carried in the low bits of the 32-bit buses.

A packed status word reports the fill level, counted in entries of the current width, together with a full flag and an empty flag. A programmable threshold drives a one-cycle event. On a transmit-side instance the event fires when draining brings the level down to the threshold. On a receive-side instance it fires when filling brings the level up to it. A single operation write both clears the pointers and runs or halts the buffer.

A two-state controller governs access. ST_HALT is entered at reset; in it both handshakes are refused and the contents are held. ST_RUN is the state in which the buffer accepts and delivers data. Transition START (ST_HALT to ST_RUN) is taken on an operation write with the run bit set. Transition STOP (ST_RUN to ST_HALT) is taken on an operation write with the run bit clear. Any other operation write leaves the state where it is.

Top module: `spi_wfifo`

## Requirements
- R1: After reset the controller is halted: `in_ready` and `out_valid` are 0, `thr_evt` is 0, and `status_word` is 0x200 (empty set, full clear, level 0). The empty and full flags are never set together.
- R2: An operation write (`op_wr`=1) with `op_cmd[1]`=1 runs the buffer; one with `op_cmd[1]`=0 halts it. While halted, `in_ready` and `out_valid` are 0, no push or pop is accepted, and the level and stored entries are kept for when the buffer runs again.
- R3: An operation write with `op_cmd[0]`=1 discards all contents, so the next status reads empty with level 0. This clear overrides any push or pop in the same cycle.
- R4: `cfg_width` selects the entry size: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, and 3 acts as 32-bit. Entries leave in the order they entered. The low bits of `in_data` are stored, and the unused upper bits of `out_data` read 0.
- R5: The level counts entries of the current width, so the capacity is 256, 128 or 64 entries. `status_word` packs the level in bits [7:0], full in bit 8 and empty in bit 9. When full, `in_ready` is 0. A full buffer in 8-bit mode therefore reads 0x100.
- R6: Level and flags change at the same clock edge that accepts the push or pop that changes them.
- R7: A push and a pop accepted in the same cycle leave the level unchanged and keep the order.
- R8: With `cfg_rx_side`=0, `thr_evt` pulses for one cycle after a pop brings the level down to `cfg_thresh`. A push that raises the level to the threshold does not fire it.
- R9: With `cfg_rx_side`=1, `thr_evt` pulses for one cycle after a push brings the level up to `cfg_thresh`. A pop that lowers the level to the threshold does not fire it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_wr | input | 1 | Operation write strobe |
| op_cmd | input | 2 | Bit 0: clear pointers; bit 1: run (0 halts) |
| cfg_width | input | 2 | Entry width code |
| cfg_thresh | input | 8 | Threshold level in entries |
| cfg_rx_side | input | 1 | 0: event on falling level; 1: event on rising level |
| in_valid | input | 1 | Push request |
| in_ready | output | 1 | Push accepted when high with in_valid |
| in_data | input | 32 | Push data, low bits used |
| out_valid | output | 1 | An entry is available |
| out_ready | input | 1 | Pop request |
| out_data | output | 32 | Oldest entry, zero-extended |
| status_word | output | 10 | {empty, full, level[7:0]} |
| thr_evt | output | 1 | One-cycle threshold event |

## Verification
Two functions can fall in the same clock: a push and a pop, and an operation clear together with either. The bench raises `in_valid` and `out_ready` in the same cycle on a partly filled buffer. It then requires the level to read the same and the drained data to keep arrival order. The clear case is judged by an empty status after an operation write that lands on a filled buffer.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0,
        W_HALF = 2'd1,
        W_WORD = 2'd2,
        W_RSVD = 2'd3
    } ent_width_e;

    // log2 of the bytes per entry; the reserved code maps to 32-bit
    function automatic logic [1:0] width_shift(input logic [1:0] code);
        logic [1:0] sh;
        unique case (ent_width_e'(code))
            W_BYTE:  sh = 2'd0;
            W_HALF:  sh = 2'd1;
            W_WORD:  sh = 2'd2;
            W_RSVD:  sh = 2'd2;
            default: sh = 2'd0;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/wfifo_ctrl.sv
module wfifo_ctrl
    import wfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_wr,
    input  logic [1:0] op_cmd,
    output logic       running,
    output logic       clr
);

    run_state_e state_q, state_d;

    // next-state: START and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (op_wr && op_cmd[1])  state_d = ST_RUN;
            ST_RUN:  if (op_wr && !op_cmd[1]) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUN);
        clr     = op_wr && op_cmd[0];
    end

endmodule

// File: rtl/wfifo_occ.sv
module wfifo_occ #(
    parameter int CAP_BYTES = 256,
    localparam int PTR_W = $clog2(CAP_BYTES),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [1:0]       shift,
    input  logic [PTR_W-1:0] thresh,
    input  logic             rx_side,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             thr_evt
);

    logic [CNT_W-1:0] cnt, cnt_nxt, ebytes, ents_now, ents_nxt;
    logic             evt_nxt;

    always_comb begin
        ebytes   = CNT_W'(1) << shift;
        full     = cnt > (CNT_W'(CAP_BYTES) - ebytes);
        empty    = cnt < ebytes;
        ents_now = cnt >> shift;
        level    = ents_now[PTR_W-1:0];
        unique case ({push, pop})
            2'b10:   cnt_nxt = cnt + ebytes;
            2'b01:   cnt_nxt = cnt - ebytes;
            default: cnt_nxt = cnt;
        endcase
        ents_nxt = cnt_nxt >> shift;
        evt_nxt  = !clr && (ents_nxt == {1'b0, thresh}) &&
                   (rx_side ? (ents_nxt > ents_now) : (ents_nxt < ents_now));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            thr_evt <= 1'b0;
        end else if (clr) begin
            cnt     <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            thr_evt <= 1'b0;
        end else begin
            cnt     <= cnt_nxt;
            thr_evt <= evt_nxt;
            if (push) wr_ptr <= wr_ptr + PTR_W'(ebytes);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(ebytes);
        end
    end

endmodule

// File: rtl/wfifo_mem.sv
module wfifo_mem #(
    parameter int CAP_BYTES = 256,
    parameter int LANES     = 4,
    localparam int PTR_W = $clog2(CAP_BYTES)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [LANES-1:0]   lane_en,
    input  logic [PTR_W-1:0]   wr_ptr,
    input  logic [PTR_W-1:0]   rd_ptr,
    input  logic [8*LANES-1:0] wdata,
    output logic [8*LANES-1:0] rdata
);

    logic [7:0] mem [CAP_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_en[l]) mem[wr_ptr + PTR_W'(l)] <= wdata[8*l +: 8];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rdata[8*g +: 8] = lane_en[g] ? mem[rd_ptr + PTR_W'(g)] : 8'h00;
    end

endmodule

// File: rtl/spi_wfifo.sv
module spi_wfifo
    import wfifo_pkg::*;
#(
    parameter int CAP_BYTES = 256,
    parameter int BUS_W     = 32,
    localparam int LANES  = BUS_W / 8,
    localparam int PTR_W  = $clog2(CAP_BYTES),
    localparam int STAT_W = PTR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_wr,
    input  logic [1:0]        op_cmd,
    input  logic [1:0]        cfg_width,
    input  logic [PTR_W-1:0]  cfg_thresh,
    input  logic              cfg_rx_side,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BUS_W-1:0]  in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BUS_W-1:0]  out_data,
    output logic [STAT_W-1:0] status_word,
    output logic              thr_evt
);

    logic             running, clr, push, pop, full, empty;
    logic [1:0]       shift;
    logic [LANES-1:0] lane_en;
    logic [PTR_W-1:0] wr_ptr, rd_ptr, level;

    assign shift = width_shift(cfg_width);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = 32'(g) < (32'd1 << shift);
    end

    assign in_ready    = running && !full;
    assign out_valid   = running && !empty;
    assign push        = in_valid && in_ready;
    assign pop         = out_valid && out_ready;
    assign status_word = {empty, full, level};

    wfifo_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_wr   (op_wr),
        .op_cmd  (op_cmd),
        .running (running),
        .clr     (clr)
    );

    wfifo_occ #(.CAP_BYTES(CAP_BYTES)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .push    (push),
        .pop     (pop),
        .shift   (shift),
        .thresh  (cfg_thresh),
        .rx_side (cfg_rx_side),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .level   (level),
        .full    (full),
        .empty   (empty),
        .thr_evt (thr_evt)
    );

    wfifo_mem #(.CAP_BYTES(CAP_BYTES), .LANES(LANES)) u_mem (
        .clk     (clk),
        .we      (push),
        .lane_en (lane_en),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .wdata   (in_data),
        .rdata   (out_data)
    );

endmodule

// File: rtl/wfifo_chk.sv
module wfifo_chk #(
    parameter int STAT_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_wr,
    input logic [1:0]        op_cmd,
    input logic [1:0]        cfg_width,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [STAT_W-1:0] status_word,
    input logic              thr_evt
);

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_word[STAT_W-1:STAT_W-2]));

    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[STAT_W-2] |-> !in_ready);

    a_r2_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && !op_cmd[1]) |=> (!in_ready && !out_valid));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_wr && !(in_valid && in_ready) && !(out_valid && out_ready))
        |=> ($stable(status_word) || !$stable(cfg_width)));

    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op_cmd[0]) |=> (status_word[STAT_W-1] && status_word[STAT_W-3:0] == '0));

    a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_wr && in_valid && in_ready && out_valid && out_ready)
        |=> ($stable(status_word) || !$stable(cfg_width)));

    a_r8_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        thr_evt |=> !thr_evt);

endmodule

bind spi_wfifo wfifo_chk #(.STAT_W(STAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_wr       (op_wr),
    .op_cmd      (op_cmd),
    .cfg_width   (cfg_width),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .status_word (status_word),
    .thr_evt     (thr_evt)
);

// File: tb/tb_spi_wfifo.sv
`timescale 1ns/1ps
module tb_spi_wfifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_wr = 1'b0;
    logic [1:0]  op_cmd = 2'b00;
    logic [1:0]  cfg_width = 2'd0;
    logic [7:0]  cfg_thresh = 8'd0;
    logic        cfg_rx_side = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [9:0]  status_word;
    logic        thr_evt;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    spi_wfifo dut (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_cmd(op_cmd),
        .cfg_width(cfg_width), .cfg_thresh(cfg_thresh), .cfg_rx_side(cfg_rx_side),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .status_word(status_word), .thr_evt(thr_evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] c);
        @(negedge clk); op_wr = 1'b1; op_cmd = c;
        @(negedge clk); op_wr = 1'b0; op_cmd = 2'b00;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); in_valid = 1'b1; in_data = d;
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic pop(output logic [31:0] d);
        @(negedge clk); d = out_data; out_ready = 1'b1;
        @(negedge clk); out_ready = 1'b0;
    endtask

    task automatic restart(input logic [1:0] w, input logic rx, input logic [7:0] th);
        @(negedge clk); cfg_width = w; cfg_rx_side = rx; cfg_thresh = th;
        op(2'b11);
    endtask

    task automatic t_reset;
        chk("R1 status at reset", 32'(status_word), 32'h200);
        chk("R1 in_ready at reset", 32'(in_ready), 32'h0);
        chk("R1 out_valid at reset", 32'(out_valid), 32'h0);
        chk("R1 thr_evt at reset", 32'(thr_evt), 32'h0);
        push(32'h55);
        chk("R2 push refused while halted", 32'(status_word), 32'h200);
    endtask

    task automatic t_bytes;
        logic [31:0] d;
        restart(2'd0, 1'b0, 8'hFF);
        push(32'hAABBCCA1);
        chk("R6 level after one push", 32'(status_word), 32'h001);
        push(32'h000000B2);
        push(32'h000000C3);
        chk("R5 level three bytes", 32'(status_word), 32'h003);
        pop(d); chk("R4 byte order 0", d, 32'hA1);
        pop(d); chk("R4 byte order 1", d, 32'hB2);
        pop(d); chk("R4 byte order 2", d, 32'hC3);
        chk("R6 empty after drain", 32'(status_word), 32'h200);
    endtask

    task automatic t_half;
        logic [31:0] d;
        restart(2'd1, 1'b0, 8'hFF);
        push(32'hFFFF1234);
        push(32'h0000ABCD);
        chk("R5 halfword level", 32'(status_word), 32'h002);
        pop(d); chk("R4 halfword 0 zero-extended", d, 32'h1234);
        pop(d); chk("R4 halfword 1", d, 32'hABCD);
        restart(2'd3, 1'b0, 8'hFF);
        push(32'hCAFEF00D);
        pop(d); chk("R4 reserved code acts as 32-bit", d, 32'hCAFEF00D);
    endtask

    task automatic t_word_full;
        logic [31:0] d;
        restart(2'd2, 1'b0, 8'hFF);
        for (int i = 0; i < 64; i++) push(32'h1000_0000 + 32'(i));
        chk("R5 32-bit full status", 32'(status_word), 32'h140);
        chk("R5 in_ready low when full", 32'(in_ready), 32'h0);
        push(32'hDEADBEEF);
        chk("R5 push refused when full", 32'(status_word), 32'h140);
        for (int i = 0; i < 64; i++) begin
            pop(d);
            if (i == 0 || i == 63) chk("R4 32-bit order", d, 32'h1000_0000 + 32'(i));
        end
        chk("R5 drained 32-bit", 32'(status_word), 32'h200);
    endtask

    task automatic t_byte_full;
        restart(2'd0, 1'b0, 8'hFF);
        for (int i = 0; i < 256; i++) push(32'(i));
        chk("R5 byte full reads 0x100", 32'(status_word), 32'h100);
        op(2'b11);
        chk("R3 clear empties", 32'(status_word), 32'h200);
    endtask

    task automatic t_halt_hold;
        logic [31:0] d;
        restart(2'd0, 1'b0, 8'hFF);
        push(32'h11);
        push(32'h22);
        op(2'b00);
        chk("R2 in_ready low halted", 32'(in_ready), 32'h0);
        chk("R2 out_valid low halted", 32'(out_valid), 32'h0);
        @(negedge clk); in_valid = 1'b1; in_data = 32'h99; out_ready = 1'b1;
        @(negedge clk); in_valid = 1'b0; out_ready = 1'b0;
        chk("R2 level held while halted", 32'(status_word), 32'h002);
        op(2'b10);
        pop(d); chk("R2 contents kept after rerun", d, 32'h11);
        pop(d); chk("R2 second kept entry", d, 32'h22);
    endtask

    task automatic t_simul;
        logic [31:0] d;
        restart(2'd0, 1'b0, 8'hFF);
        push(32'h31);
        push(32'h32);
        @(negedge clk);
        d = out_data; in_valid = 1'b1; in_data = 32'h33; out_ready = 1'b1;
        @(negedge clk); in_valid = 1'b0; out_ready = 1'b0;
        chk("R7 simultaneous level unchanged", 32'(status_word), 32'h002);
        chk("R7 simultaneous pop data", d, 32'h31);
        pop(d); chk("R7 order after simultaneous", d, 32'h32);
        pop(d); chk("R7 pushed entry last", d, 32'h33);
        push(32'h41);
        push(32'h42);
        @(negedge clk); in_valid = 1'b1; in_data = 32'h43; op_wr = 1'b1; op_cmd = 2'b11;
        @(negedge clk); in_valid = 1'b0; op_wr = 1'b0; op_cmd = 2'b00;
        chk("R3 clear beats push", 32'(status_word), 32'h200);
    endtask

    task automatic t_tx_evt;
        logic [31:0] d;
        restart(2'd0, 1'b0, 8'd2);
        push(32'h1);
        push(32'h2);
        chk("R8 rising to threshold does not fire", 32'(thr_evt), 32'h0);
        push(32'h3);
        push(32'h4);
        pop(d);
        chk("R8 no event at level 3", 32'(thr_evt), 32'h0);
        pop(d);
        chk("R8 event on falling to threshold", 32'(thr_evt), 32'h1);
        @(negedge clk);
        chk("R8 event is one cycle", 32'(thr_evt), 32'h0);
    endtask

    task automatic t_rx_evt;
        logic [31:0] d;
        restart(2'd0, 1'b1, 8'd3);
        push(32'h1);
        push(32'h2);
        chk("R9 no event below threshold", 32'(thr_evt), 32'h0);
        push(32'h3);
        chk("R9 event on rising to threshold", 32'(thr_evt), 32'h1);
        push(32'h4);
        chk("R9 no event above threshold", 32'(thr_evt), 32'h0);
        pop(d);
        chk("R9 falling to threshold does not fire", 32'(thr_evt), 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_half();
        t_word_full();
        t_byte_full();
        t_halt_hold();
        t_simul();
        t_tx_evt();
        t_rx_evt();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule